// File: doc/BRIEF.md
# Serial-Loaded Switch Control Register

This block is the digital control core of an eight-channel switch bank. It collects switch settings one bit at a time through a serial data input, which is clocked by a slow shift clock. A level-controlled hold register passes the collected pattern to eight switch-enable outputs. A serial output carries the last shift stage, so that several banks can be cascaded on one serial line. A clear input turns every switch off.

The block runs on a fast system clock. The shift clock, serial data, hold control and clear are treated as asynchronous levels. Each of them is synchronised through a short flop chain, and the shift clock is edge-detected after synchronisation.

While the hold control is low, the register is transparent and the switch outputs track the shift stages. Raising the hold control freezes the outputs. The application therefore loads a full pattern with the hold control high, then pulses it low to apply the pattern.

Top module: `swctl_core`

## Requirements
- R1: Each rising edge of `shift_clk` moves every shift stage k-1 into stage k and loads `ser_in` into stage 0. The bit loaded first therefore reaches stage 7 after eight edges.
- R2: `ser_out` equals the content of stage 7, the last shift stage. This holds both while clear is asserted and while it is released.
- R3: While `hold_en` is low and `clear` is low, `sw_en` follows the shift stages after each shift.
- R4: While `hold_en` is high, any number of shifts leaves `sw_en` unchanged.
- R5: A rising edge of `hold_en` freezes `sw_en` at the pattern held in the shift stages when the edge arrives.
- R6: While `clear` is high, `sw_en` is all zeros. This overrides both the transparent state and the shifting.
- R7: Clear does not change the shift stages. If `hold_en` is high when clear is released, `sw_en` stays zero until `hold_en` goes low. It then shows the unchanged shift contents.
- R8: `sw_en[k]` is driven by stage k alone, with 1 meaning on. Every one of the 256 patterns reaches the outputs unchanged.
- R9: Reset, which is synchronous and active high, sets all stages, `sw_en` and `ser_out` to zero.
- R10: After a change of `hold_en`, `sw_en` shows the new state after the third system clock edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data, sampled on the shift clock's rising edge |
| shift_clk | input | 1 | Slow shift clock, asynchronous to clk |
| hold_en | input | 1 | Low: transparent; high: outputs frozen |
| clear | input | 1 | Forces every switch off while high |
| ser_out | output | 1 | Content of the last shift stage, for cascading |
| sw_en | output | 8 | Switch enables, 1 = on |

## Verification
The assertions assume that `ser_in` is stable for the synchroniser depth around every rising edge of `shift_clk`. This assumption lets the data and the detected edge line up after synchronisation. They also assume that every control level is held for several system clocks. The stimulus meets both assumptions: it sets the data two system clocks before raising the shift clock and keeps it there until the next bit. Each shift-clock phase and each hold or clear level lasts at least four system clocks.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
  parameter int unsigned SWCTL_CHANNELS = 8;
  parameter int unsigned SWCTL_SYNC     = 2;
  // index of each control input in the synchroniser bank
  parameter int unsigned IDX_SCLK  = 0;
  parameter int unsigned IDX_DATA  = 1;
  parameter int unsigned IDX_HOLD  = 2;
  parameter int unsigned IDX_CLEAR = 3;
  parameter int unsigned NUM_CTL   = 4;
endpackage

// File: rtl/swctl_sync.sv
module swctl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int unsigned TOP = STAGES - 1;
  logic [TOP:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else begin
      chain[0] <= d;
      for (int i = 1; i <= int'(TOP); i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[TOP];
endmodule

// File: rtl/swctl_shift.sv
module swctl_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_lvl,
  input  logic         din_lvl,
  output logic         rise,
  output logic [W-1:0] stage_q
);
  logic sclk_prev;

  assign rise = sclk_lvl & ~sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      stage_q   <= '0;
    end else begin
      sclk_prev <= sclk_lvl;
      if (rise) stage_q <= {stage_q[W-2:0], din_lvl};
    end
  end
endmodule

// File: rtl/swctl_latch.sv
module swctl_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (!hold) q <= d;
  end
endmodule

// File: rtl/swctl_core.sv
module swctl_core
  import swctl_pkg::*;
#(
  parameter int unsigned CHANNELS = SWCTL_CHANNELS,
  parameter int unsigned SYNC     = SWCTL_SYNC
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_in,
  input  logic                shift_clk,
  input  logic                hold_en,
  input  logic                clear,
  output logic                ser_out,
  output logic [CHANNELS-1:0] sw_en
);
  localparam int unsigned LAST = CHANNELS - 1;

  logic [NUM_CTL-1:0] ctl_raw;
  logic [NUM_CTL-1:0] ctl_lvl;
  logic               sclk_rise;
  logic               hold_lvl;
  logic               clr_lvl;
  logic [LAST:0]      stage_q;

  assign ctl_raw[IDX_SCLK]  = shift_clk;
  assign ctl_raw[IDX_DATA]  = ser_in;
  assign ctl_raw[IDX_HOLD]  = hold_en;
  assign ctl_raw[IDX_CLEAR] = clear;

  for (genvar g = 0; g < NUM_CTL; g++) begin : g_sync
    swctl_sync #(.STAGES(SYNC)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (ctl_raw[g]),
      .q   (ctl_lvl[g])
    );
  end

  assign hold_lvl = ctl_lvl[IDX_HOLD];
  assign clr_lvl  = ctl_lvl[IDX_CLEAR];

  swctl_shift #(.W(CHANNELS)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .sclk_lvl (ctl_lvl[IDX_SCLK]),
    .din_lvl  (ctl_lvl[IDX_DATA]),
    .rise     (sclk_rise),
    .stage_q  (stage_q)
  );

  swctl_latch #(.W(CHANNELS)) u_latch (
    .clk  (clk),
    .rst  (rst),
    .hold (hold_lvl),
    .clr  (clr_lvl),
    .d    (stage_q),
    .q    (sw_en)
  );

  assign ser_out = stage_q[LAST];
endmodule

// File: rtl/swctl_core_chk.sv
module swctl_core_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         sclk_rise,
  input logic         hold_lvl,
  input logic         clr_lvl,
  input logic [W-1:0] stage_q,
  input logic         ser_out,
  input logic [W-1:0] sw_en
);
  assert_shift_step_R1: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |=> stage_q[W-1:1] == $past(stage_q[W-2:0]));

  assert_serial_tap_R2: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |=> ser_out == $past(stage_q[W-2]));

  assert_transparent_R3: assert property (@(posedge clk) disable iff (rst)
    (!hold_lvl && !clr_lvl) |=> sw_en == $past(stage_q));

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (hold_lvl && !clr_lvl) |=> $stable(sw_en));

  assert_clear_off_R6: assert property (@(posedge clk) disable iff (rst)
    clr_lvl |=> sw_en == '0);

  assert_clear_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    !sclk_rise |=> $stable(stage_q));

  assert_reset_off_R9: assert property (@(posedge clk)
    rst |=> (sw_en == '0 && !ser_out));
endmodule

bind swctl_core swctl_core_chk #(.W(CHANNELS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sclk_rise (sclk_rise),
  .hold_lvl  (hold_lvl),
  .clr_lvl   (clr_lvl),
  .stage_q   (stage_q),
  .ser_out   (ser_out),
  .sw_en     (sw_en)
);

// File: tb/swctl_core_bench.sv
module swctl_core_bench;
  localparam int CH = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ser_in = 1'b0;
  logic          shift_clk = 1'b0;
  logic          hold_en = 1'b1;
  logic          clear = 1'b0;
  logic          ser_out;
  logic [CH-1:0] sw_en;

  int total = 0;
  int fails = 0;
  logic [CH-1:0] model = '0;
  logic [CH-1:0] expo = '0;
  logic [CH-1:0] snap;

  always #2 clk = ~clk;

  swctl_core u_swctl_core (
    .clk       (clk),
    .rst       (rst),
    .ser_in    (ser_in),
    .shift_clk (shift_clk),
    .hold_en   (hold_en),
    .clear     (clear),
    .ser_out   (ser_out),
    .sw_en     (sw_en)
  );

  task automatic chk(input string req, input logic [CH-1:0] act, input logic [CH-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk) ser_in = b;
    waitn(2);
    shift_clk = 1'b1;
    waitn(4);
    shift_clk = 1'b0;
    waitn(4);
    model = {model[CH-2:0], b};
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog R10 actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic b;
    waitn(5);
    rst = 1'b0;
    waitn(2);
    chk("R9 reset sw_en", sw_en, '0);
    chk("R9 reset ser_out", {7'b0, ser_out}, '0);

    // full sweep of patterns, loaded while held then applied
    for (int v = 0; v < 256; v++) begin
      for (int i = CH - 1; i >= 0; i--) shift_bit(v[i]);
      chk("R4 held during load", sw_en, expo);
      chk("R2 ser_out is stage 7", {7'b0, ser_out}, {7'b0, model[CH-1]});
      chk("R1 first bit at stage 7", {7'b0, ser_out}, {7'b0, v[7]});
      hold_en = 1'b0;
      waitn(8);
      chk("R8 pattern applied", sw_en, v[CH-1:0]);
      expo = v[CH-1:0];
      hold_en = 1'b1;
      waitn(8);
    end

    // transparent tracking
    hold_en = 1'b0;
    waitn(8);
    for (int i = 0; i < 10; i++) begin
      shift_bit((i % 3) == 0);
      chk("R3 transparent follow", sw_en, model);
      chk("R1 shift step ser_out", {7'b0, ser_out}, {7'b0, model[CH-1]});
    end

    // freeze on rising hold
    hold_en = 1'b1;
    waitn(8);
    snap = model;
    shift_bit(1'b1);
    shift_bit(1'b0);
    shift_bit(1'b1);
    chk("R5 frozen at rising hold", sw_en, snap);

    // clear behaviour
    hold_en = 1'b0;
    waitn(8);
    chk("R3 transparent before clear", sw_en, model);
    clear = 1'b1;
    waitn(8);
    chk("R6 clear forces off", sw_en, '0);
    shift_bit(1'b1);
    shift_bit(1'b1);
    chk("R6 clear overrides shifting", sw_en, '0);
    chk("R2 ser_out during clear", {7'b0, ser_out}, {7'b0, model[CH-1]});
    hold_en = 1'b1;
    waitn(4);
    clear = 1'b0;
    waitn(8);
    chk("R7 held zero after clear", sw_en, '0);
    hold_en = 1'b0;
    waitn(8);
    chk("R7 shift contents kept", sw_en, model);

    // latency of hold release
    hold_en = 1'b1;
    waitn(8);
    snap = model;
    b = ~model[0];
    shift_bit(b);
    @(negedge clk) hold_en = 1'b0;
    waitn(2);
    chk("R10 not yet after 2 edges", sw_en, snap);
    waitn(1);
    chk("R10 applied after 3 edges", sw_en, model);

    // reset mid-run
    rst = 1'b1;
    waitn(3);
    rst = 1'b0;
    waitn(2);
    chk("R9 reset mid-run sw_en", sw_en, '0);
    chk("R9 reset mid-run ser_out", {7'b0, ser_out}, '0);
    model = '0;
    shift_bit(1'b1);
    chk("R9 stages cleared by reset", sw_en, 8'h01);

    finish_run();
  end
endmodule